// File: doc/BRIEF.md
# Shader Loop Control Unit

This unit carries out the two loop control-flow operations of a shader sequencer: opening a loop and closing one. For each operation it decides whether control jumps or falls through, and it gives the next program counter. It keeps a small stack of active loops. Each entry holds the trip count, the iteration index, the signed step and the current address-register value. A neighbouring decoder supplies the operation code, the current and target addresses, the repeat and break flags, and the 32-bit loop constant word that was fetched for the operation. A predicate aggregator supplies two flags. One says the predicate is true in every active invocation. The other says it is false in every active invocation.

The address register follows iteration × step + start in 10-bit two's complement. It is updated by adding the step once per completed iteration. It appears on `al_o` one cycle after the operation that changes it. A loop whose count is zero is skipped at its opening and takes no stack entry. Overflow or underflow of the stack raises a sticky error flag.

Top module: `loop_ctrl`

## Requirements
- R1: The loop constant word gives the trip count in bits 7:0 (unsigned), the start value in bits 15:8 (unsigned) and the step in bits 23:16 (two's complement). Bits 31:24 are ignored.
- R2: A loop-open operation (`op_i` = 1) with a trip count of zero asserts `jump_o`, drives `next_pc_o` = `target_i` and leaves the depth unchanged. This holds even when the stack is full, and the error flag is not set.
- R3: A loop-open operation with a non-zero count on a stack that is not full pushes a level with iteration 0. It does not jump and drives `next_pc_o` = `pc_i` + 1. One cycle later, `depth_o` is one higher and `al_o` equals the start value.
- R4: When `repeat_i` is set on a loop-open push, the new level takes the address-register value that was visible before the push (0 on an empty stack) instead of the start value.
- R5: A loop-close operation (`op_i` = 2) on a non-empty stack first increments the top iteration. If the incremented iteration is below the trip count and no break is taken, it asserts `jump_o` with `next_pc_o` = `target_i`, and one cycle later `al_o` has advanced by the step.
- R6: When the incremented iteration reaches the trip count, a loop-close operation falls through (`next_pc_o` = `pc_i` + 1) and pops one level.
- R7: With `brk_en_i` set, a loop-close operation exits and pops when `brk_cond_i` = 1 and `pred_all_set_i` = 1, or when `brk_cond_i` = 0 and `pred_all_clear_i` = 1. Otherwise the predicate has no effect. When the break and count exhaustion coincide, exactly one level is popped.
- R8: The address register wraps modulo 1024 as a 10-bit two's complement value.
- R9: At most DEPTH (4) levels are held. A non-zero-count loop-open on a full stack sets `err_o`, does not jump, and leaves the depth and `al_o` unchanged.
- R10: A loop-close on an empty stack sets `err_o`, does not jump and leaves the depth at 0.
- R11: After a level is popped, the enclosing level's address register appears on `al_o` on the next cycle, unchanged by the inner loop (0 when none remains).
- R12: Reset clears the depth, `al_o` and `err_o`. Once set, `err_o` stays set until reset.
- R13: With `op_i` = 0 or 3, `jump_o` is low, `next_pc_o` = `pc_i` + 1, and the depth and `al_o` do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 2 | Operation: 0 none, 1 loop open, 2 loop close, 3 none |
| pc_i | input | PC_W | Address of the current operation |
| target_i | input | PC_W | Skip address (open) or body address (close) |
| const_i | input | 32 | Loop constant word |
| repeat_i | input | 1 | Keep the current address register on open |
| brk_en_i | input | 1 | Close carries a predicated break |
| brk_cond_i | input | 1 | Predicate value that triggers the break |
| pred_all_set_i | input | 1 | Predicate true in all active invocations |
| pred_all_clear_i | input | 1 | Predicate false in all active invocations |
| jump_o | output | 1 | Control transfers to `target_i` |
| next_pc_o | output | PC_W | Next program counter |
| al_o | output | 10 | Current address register, two's complement |
| depth_o | output | $clog2(DEPTH+1) | Active loop levels |
| err_o | output | 1 | Sticky stack overflow or underflow |

## Verification
Two pairs of functions can collide in a single operation. In the first, a zero-count skip arrives while the stack is already full. The bench fills four levels, issues an overflowing open and then a zero-count open, and expects the skip to win: a jump, no push and no extra error. In the second, a predicated break fires on the same close that exhausts the trip count. The bench opens a single-iteration loop and closes it with a matching break, and expects one pop and a fall-through. A behavioural reference model computes the address register as base plus iteration times step, so it is compared on every clock against the design's incremental adder.

// File: rtl/loop_pkg.sv
`timescale 1ns/1ps
package loop_pkg;
  localparam int CNT_W = 8;
  localparam int AL_W  = 10;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_OPEN  = 2'd1,
    OP_CLOSE = 2'd2,
    OP_RSVD  = 2'd3
  } op_e;

  typedef struct packed {
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] start;
    logic [CNT_W-1:0] step;
  } lconst_t;

  typedef struct packed {
    logic [CNT_W-1:0] count;
    logic [CNT_W-1:0] iter;
    logic [CNT_W-1:0] step;
    logic [AL_W-1:0]  al;
  } level_t;

  function automatic lconst_t unpack_const(input logic [31:0] w);
    lconst_t c;
    c.count = w[7:0];
    c.start = w[15:8];
    c.step  = w[23:16];
    return c;
  endfunction

  function automatic logic [AL_W-1:0] sext_step(input logic [CNT_W-1:0] s);
    return {{(AL_W-CNT_W){s[CNT_W-1]}}, s};
  endfunction
endpackage

// File: rtl/loop_decide.sv
`timescale 1ns/1ps
module loop_decide
  import loop_pkg::*;
#(
  parameter  int DEPTH = 4,
  parameter  int PC_W  = 12,
  localparam int DW    = $clog2(DEPTH+1)
) (
  input  op_e             op_i,
  input  logic [31:0]     const_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] target_i,
  input  logic            repeat_i,
  input  logic            brk_en_i,
  input  logic            brk_cond_i,
  input  logic            pred_all_set_i,
  input  logic            pred_all_clear_i,
  input  level_t          top_i,
  input  logic [DW-1:0]   depth_i,
  output logic            jump_o,
  output logic [PC_W-1:0] next_pc_o,
  output logic            push_o,
  output logic            pop_o,
  output logic            adv_o,
  output logic            err_o,
  output level_t          push_lvl_o,
  output level_t          adv_lvl_o
);
  lconst_t          lc;
  logic             empty, full, brk;
  logic [CNT_W:0]   iter_nx;
  logic [AL_W-1:0]  cur_al;

  assign lc      = unpack_const(const_i);
  assign empty   = (depth_i == '0);
  assign full    = (depth_i == DW'(DEPTH));
  assign cur_al  = empty ? '0 : top_i.al;
  assign iter_nx = {1'b0, top_i.iter} + 1'b1;
  assign brk     = brk_en_i && (brk_cond_i ? pred_all_set_i : pred_all_clear_i);

  always_comb begin
    push_lvl_o.count = lc.count;
    push_lvl_o.iter  = '0;
    push_lvl_o.step  = lc.step;
    push_lvl_o.al    = repeat_i ? cur_al : {{(AL_W-CNT_W){1'b0}}, lc.start};

    adv_lvl_o       = top_i;
    adv_lvl_o.iter  = iter_nx[CNT_W-1:0];
    adv_lvl_o.al    = top_i.al + sext_step(top_i.step);
  end

  always_comb begin
    jump_o = 1'b0;
    push_o = 1'b0;
    pop_o  = 1'b0;
    adv_o  = 1'b0;
    err_o  = 1'b0;
    unique case (op_i)
      OP_OPEN: begin
        if (lc.count == '0)  jump_o = 1'b1;  // skip wins over overflow
        else if (full)       err_o  = 1'b1;
        else                 push_o = 1'b1;
      end
      OP_CLOSE: begin
        if (empty) err_o = 1'b1;
        else if (iter_nx < {1'b0, top_i.count} && !brk) begin
          jump_o = 1'b1;
          adv_o  = 1'b1;
        end else pop_o = 1'b1;
      end
      default: ;
    endcase
  end

  assign next_pc_o = jump_o ? target_i : pc_i + PC_W'(1);
endmodule

// File: rtl/loop_stack.sv
`timescale 1ns/1ps
module loop_stack
  import loop_pkg::*;
#(
  parameter  int DEPTH = 4,
  localparam int DW    = $clog2(DEPTH+1),
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic          pop_i,
  input  logic          adv_i,
  input  level_t        push_lvl_i,
  input  level_t        adv_lvl_i,
  output level_t        top_o,
  output logic [DW-1:0] depth_o
);
  level_t        lvl_q [DEPTH];
  logic [DW-1:0] depth_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      depth_q <= '0;
      for (int i = 0; i < DEPTH; i++) lvl_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (push_i && depth_q == DW'(i))       lvl_q[i] <= push_lvl_i;
        else if (adv_i && depth_q == DW'(i+1)) lvl_q[i] <= adv_lvl_i;
      end
      if (push_i)     depth_q <= depth_q + 1'b1;
      else if (pop_i) depth_q <= depth_q - 1'b1;
    end
  end

  assign top_o   = (depth_q == '0) ? '0 : lvl_q[AW'(depth_q - 1'b1)];
  assign depth_o = depth_q;
endmodule

// File: rtl/loop_ctrl.sv
`timescale 1ns/1ps
module loop_ctrl
  import loop_pkg::*;
#(
  parameter  int DEPTH = 4,
  parameter  int PC_W  = 12,
  localparam int DW    = $clog2(DEPTH+1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      op_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic [PC_W-1:0] target_i,
  input  logic [31:0]     const_i,
  input  logic            repeat_i,
  input  logic            brk_en_i,
  input  logic            brk_cond_i,
  input  logic            pred_all_set_i,
  input  logic            pred_all_clear_i,
  output logic            jump_o,
  output logic [PC_W-1:0] next_pc_o,
  output logic [AL_W-1:0] al_o,
  output logic [DW-1:0]   depth_o,
  output logic            err_o
);
  level_t top, push_lvl, adv_lvl;
  logic   push, pop, adv, err_ev, err_q;

  loop_decide #(.DEPTH(DEPTH), .PC_W(PC_W)) u_decide (
    .op_i             (op_e'(op_i)),
    .const_i          (const_i),
    .pc_i             (pc_i),
    .target_i         (target_i),
    .repeat_i         (repeat_i),
    .brk_en_i         (brk_en_i),
    .brk_cond_i       (brk_cond_i),
    .pred_all_set_i   (pred_all_set_i),
    .pred_all_clear_i (pred_all_clear_i),
    .top_i            (top),
    .depth_i          (depth_o),
    .jump_o           (jump_o),
    .next_pc_o        (next_pc_o),
    .push_o           (push),
    .pop_o            (pop),
    .adv_o            (adv),
    .err_o            (err_ev),
    .push_lvl_o       (push_lvl),
    .adv_lvl_o        (adv_lvl)
  );

  loop_stack #(.DEPTH(DEPTH)) u_stack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .push_i     (push),
    .pop_i      (pop),
    .adv_i      (adv),
    .push_lvl_i (push_lvl),
    .adv_lvl_i  (adv_lvl),
    .top_o      (top),
    .depth_o    (depth_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (err_ev) err_q <= 1'b1;
  end

  assign err_o = err_q;
  assign al_o  = top.al;
endmodule

// File: rtl/loop_ctrl_chk.sv
`timescale 1ns/1ps
module loop_ctrl_chk #(
  parameter  int DEPTH = 4,
  parameter  int PC_W  = 12,
  localparam int DW    = $clog2(DEPTH+1)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [1:0]      op_i,
  input logic [PC_W-1:0] pc_i,
  input logic [PC_W-1:0] target_i,
  input logic [31:0]     const_i,
  input logic            jump_o,
  input logic [PC_W-1:0] next_pc_o,
  input logic [9:0]      al_o,
  input logic [DW-1:0]   depth_o,
  input logic            err_o
);
  logic is_open, is_close, is_idle, cnt_zero;
  assign is_open  = (op_i == 2'd1);
  assign is_close = (op_i == 2'd2);
  assign is_idle  = (op_i == 2'd0) || (op_i == 2'd3);
  assign cnt_zero = (const_i[7:0] == 8'd0);

  // R9
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    depth_o <= DW'(DEPTH));
  // R12
  err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  // R13
  idle_pc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_idle |-> !jump_o && next_pc_o == pc_i + PC_W'(1));
  // R13
  idle_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_idle |=> $stable(depth_o) && $stable(al_o));
  // R2
  skip_jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_open && cnt_zero |-> jump_o && next_pc_o == target_i);
  // R2
  skip_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_open && cnt_zero |=> $stable(depth_o));
  // R3
  push_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_open && !cnt_zero && depth_o < DW'(DEPTH) |=> depth_o == $past(depth_o) + 1'b1);
  // R9
  overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_open && !cnt_zero && depth_o == DW'(DEPTH) |=> err_o && $stable(depth_o) && $stable(al_o));
  // R10
  underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_close && depth_o == '0 |-> !jump_o);
  // R10
  underflow_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_close && depth_o == '0 |=> err_o && depth_o == '0);
  // R5
  back_jump_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_close && jump_o |-> next_pc_o == target_i);
  // R5
  back_depth_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_close && jump_o |=> $stable(depth_o));
  // R6
  exit_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_close && depth_o != '0 && !jump_o |=> depth_o == $past(depth_o) - 1'b1);
endmodule

bind loop_ctrl loop_ctrl_chk #(.DEPTH(DEPTH), .PC_W(PC_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .op_i      (op_i),
  .pc_i      (pc_i),
  .target_i  (target_i),
  .const_i   (const_i),
  .jump_o    (jump_o),
  .next_pc_o (next_pc_o),
  .al_o      (al_o),
  .depth_o   (depth_o),
  .err_o     (err_o)
);

// File: tb/loop_ctrl_test.sv
`timescale 1ns/1ps
module loop_ctrl_test;
  localparam int DEPTH = 4;
  localparam int PC_W  = 12;
  localparam int DW    = $clog2(DEPTH+1);

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [1:0]      op_i = '0;
  logic [PC_W-1:0] pc_i = '0, target_i = '0;
  logic [31:0]     const_i = '0;
  logic            repeat_i = 0, brk_en_i = 0, brk_cond_i = 0;
  logic            pred_all_set_i = 0, pred_all_clear_i = 0;
  logic            jump_o, err_o;
  logic [PC_W-1:0] next_pc_o;
  logic [9:0]      al_o;
  logic [DW-1:0]   depth_o;

  int checks = 0, errors = 0;
  string last_tag = "R12";

  // reference model: per-level base, iteration, step, count
  int m_base[$], m_iter[$], m_step[$], m_cnt[$];
  bit m_err = 0;

  always #2 clk_i = ~clk_i;

  loop_ctrl #(.DEPTH(DEPTH), .PC_W(PC_W)) uut (.*);

  function automatic int model_al();
    int v;
    if (m_base.size() == 0) return 0;
    v = m_base[$] + m_iter[$] * m_step[$];
    return ((v % 1024) + 1024) % 1024;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_state();
    check(last_tag, "depth", int'(depth_o), m_base.size());
    check(last_tag, "al", int'(al_o), model_al());
    check(last_tag, "err", int'(err_o), int'(m_err));
  endtask

  task automatic do_op(input int op, input int pc, input int tgt, input int cnt,
                       input int start, input int step, input bit rpt,
                       input bit ben, input bit bcond, input bit aset,
                       input bit aclr, input string tag);
    bit exp_jump;
    int exp_pc, it;
    @(negedge clk_i);
    check_state();
    op_i = op[1:0]; pc_i = pc[PC_W-1:0]; target_i = tgt[PC_W-1:0];
    const_i = {8'hA5, step[7:0], start[7:0], cnt[7:0]};  // R1: top byte ignored
    repeat_i = rpt; brk_en_i = ben; brk_cond_i = bcond;
    pred_all_set_i = aset; pred_all_clear_i = aclr;
    #1;
    exp_jump = 0;
    if (op == 1) begin
      if (cnt == 0) exp_jump = 1;
      else if (m_base.size() == DEPTH) m_err = 1;
      else begin
        int b;
        b = rpt ? model_al() : start;
        m_base.push_back(b); m_iter.push_back(0);
        m_step.push_back(step); m_cnt.push_back(cnt);
      end
    end else if (op == 2) begin
      if (m_base.size() == 0) m_err = 1;
      else begin
        it = m_iter[$] + 1;
        if (it < m_cnt[$] && !(ben && (bcond ? aset : aclr))) begin
          exp_jump = 1;
          m_iter[$] = it;
        end else begin
          void'(m_base.pop_back()); void'(m_iter.pop_back());
          void'(m_step.pop_back()); void'(m_cnt.pop_back());
        end
      end
    end
    exp_pc = exp_jump ? tgt : (pc + 1) % (1 << PC_W);
    check(tag, "jump", int'(jump_o), int'(exp_jump));
    check(tag, "next_pc", int'(next_pc_o), exp_pc);
    last_tag = tag;
  endtask

  task automatic open_loop(input int cnt, input int start, input int step,
                           input bit rpt, input string tag);
    do_op(1, 20, 90, cnt, start, step, rpt, 0, 0, 0, 0, tag);
  endtask

  task automatic close_loop(input string tag);
    do_op(2, 40, 21, 0, 0, 0, 0, 0, 0, 1, 1, tag);
  endtask

  task automatic close_brk(input bit ben, input bit bcond, input bit aset,
                           input bit aclr, input string tag);
    do_op(2, 40, 21, 0, 0, 0, 0, ben, bcond, aset, aclr, tag);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 0; op_i = '0;
    m_base.delete(); m_iter.delete(); m_step.delete(); m_cnt.delete();
    m_err = 0;
    @(negedge clk_i);
    rst_ni = 1;
    last_tag = "R12";
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    // R13 idle and reserved codes
    do_op(0, 5, 77, 3, 1, 1, 0, 0, 0, 0, 0, "R13");
    do_op(3, 4095, 77, 3, 1, 1, 0, 0, 0, 0, 0, "R13");
    // R10 close on empty
    close_loop("R10");
    do_op(0, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    do_reset();
    // R2 zero-count skip
    open_loop(0, 9, 1, 0, "R2");
    // R1 R3 R5 R6 basic loop, step 5
    open_loop(3, 10, 5, 0, "R3");
    close_loop("R5");
    close_loop("R5");
    close_loop("R6");
    // R8 wrap: 255 + k*127
    open_loop(4, 255, 127, 0, "R1");
    close_loop("R8");
    close_loop("R8");
    close_loop("R8");
    close_loop("R6");
    // R1 negative step
    open_loop(3, 3, -128, 0, "R1");
    close_loop("R1");
    close_loop("R1");
    close_loop("R6");
    // R4 R11 nesting with repeat
    open_loop(2, 100, 1, 0, "R3");
    open_loop(2, 7, 4, 1, "R4");
    close_loop("R4");
    close_loop("R11");
    close_loop("R11");
    close_loop("R11");
    // R4 repeat on empty stack
    open_loop(2, 50, 3, 1, "R4");
    close_loop("R4");
    close_loop("R6");
    // R7 predicated break variants
    open_loop(5, 0, 2, 0, "R7");
    close_brk(0, 1, 1, 0, "R7");
    close_brk(1, 0, 1, 0, "R7");
    close_brk(1, 1, 0, 1, "R7");
    close_brk(1, 1, 1, 0, "R7");
    open_loop(5, 0, 2, 0, "R7");
    close_brk(1, 0, 0, 1, "R7");
    // R7 break coinciding with count exhaustion
    open_loop(1, 30, 1, 0, "R7");
    close_brk(1, 1, 1, 0, "R7");
    // R9 overflow, then R2 skip on a full stack
    for (int k = 0; k < DEPTH; k++) open_loop(1, 10 + k, 1, 0, "R9");
    open_loop(3, 200, 1, 0, "R9");
    open_loop(0, 200, 1, 0, "R2");
    do_op(0, 8, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    for (int k = 0; k < DEPTH; k++) close_loop("R11");
    do_op(0, 9, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    // R12 reset clears error
    do_reset();
    do_op(0, 10, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    @(negedge clk_i);
    check_state();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule